// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block is a small 2D drawing engine for a 16-bit-per-pixel frame buffer. It takes 32-bit command words from a valid/ready stream. Each word has an 8-bit opcode in its top byte and an operand in the low 24 bits. Some commands only load parameters: destination address, source address, width and height. Two trigger commands use those parameters to start work. One fills a rectangle with a single colour. The other copies a source rectangle to the destination.

The frame buffer is an external synchronous single-port memory with 16-bit words. The engine drives an enable, a write strobe, a word address and write data. Read data comes back one cycle after a read is issued. Rows are `XRES` pixels apart, so pixel (x, y) of a rectangle whose base is byte address B lies at byte B + (y*XRES + x)*2.

Software sends the parameters, sends a trigger, and then polls `busy_o` (or waits for `done_o`) before it touches the frame buffer.

Top module: `rect_blit`

## Requirements
- R1: Command bits 31:24 are the opcode and bits 23:0 are the operand. `cmd_ready_o` is high whenever the engine is idle. While busy, it is low for the trigger opcodes 0x0B (fill) and 0x21 (copy), and high for every other opcode.
- R2: Opcode 0x0C loads the destination byte address and opcode 0x0D loads the source byte address. Only operand bits 23:1 are kept, so bit 0 is ignored and every address is even.
- R3: Opcode 0x0E loads the width and opcode 0x0F loads the height. Each takes operand bits 9:0 as the pixel count minus one, and bits 23:10 are ignored.
- R4: Opcode 0x0B writes operand bits 15:0 (an RGB565 pixel: red 15:11, green 10:5, blue 4:0) to every pixel of the rectangle at the destination address. Each pixel (x, y) is written at byte destination + (y*XRES + x)*2. No other memory word changes.
- R5: Opcode 0x21 (operand ignored) copies the rectangle pixel by pixel in raster order: left to right within a row, rows top to bottom. Each pixel is read from the source and then written to the destination before the next pixel is read.
- R6: The memory word address is the byte address divided by two, and read data is taken one cycle after the read. A fill issues one write per cycle. A copy alternates one read cycle and one write cycle. The memory is enabled only while the engine is busy.
- R7: `busy_o` rises in the cycle after a trigger is accepted. It stays high for width*height cycles for a fill, or 2*width*height cycles for a copy. `done_o` is a one-cycle pulse in the first cycle in which `busy_o` is low again.
- R8: Parameter loads accepted while an operation runs do not change that operation. They take effect for the next trigger.
- R9: An opcode other than 0x0B to 0x0F and 0x21 is accepted with no effect on parameters, memory or `busy_o`.
- R10: After reset the engine is idle with `busy_o`, `done_o` and `mem_en_o` low and `cmd_ready_o` high. All parameters are zero, so a fill with no loads writes only the word at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command word valid |
| cmd_ready_o | output | 1 | Command word accepted this cycle when valid |
| cmd_data_i | input | 32 | Command word: opcode 31:24, operand 23:0 |
| busy_o | output | 1 | Fill or copy in progress |
| done_o | output | 1 | One-cycle pulse when a fill or copy completes |
| mem_en_o | output | 1 | Frame buffer access enable |
| mem_we_o | output | 1 | Frame buffer write strobe |
| mem_addr_o | output | ADDR_W-1 | Frame buffer word address |
| mem_wdata_o | output | 16 | Pixel written to the frame buffer |
| mem_rdata_i | input | 16 | Pixel read from the frame buffer, one cycle after the read |

## Verification
The assertions check the handshake and sequencing rules on every cycle. Triggers stall while busy, parameter loads and idle commands are always accepted, memory is enabled only while busy, and every copy read is followed by a write. `done_o` is a single pulse that follows a busy period, and an accepted trigger raises `busy_o` on the next cycle.

The pixel results can only be shown by the bench's scenarios. These are the rectangle placement, the masking of address and extent fields, the raster order of overlapping copies, the exact busy length, and the isolation of a running operation from new parameter loads. The bench checks them by comparing the whole frame buffer against a model after each operation.

// File: rtl/rect_blit_pkg.sv
package rect_blit_pkg;
  localparam int OPER_W = 24;

  localparam logic [7:0] OP_FILL = 8'h0B;
  localparam logic [7:0] OP_DST  = 8'h0C;
  localparam logic [7:0] OP_SRC  = 8'h0D;
  localparam logic [7:0] OP_WID  = 8'h0E;
  localparam logic [7:0] OP_HGT  = 8'h0F;
  localparam logic [7:0] OP_COPY = 8'h21;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_CP_RD = 2'd2,
    ST_CP_WR = 2'd3
  } blit_state_e;
endpackage

// File: rtl/rect_cmd_decode.sv
module rect_cmd_decode
  import rect_blit_pkg::*;
(
  input  logic       cmd_valid_i,
  input  logic [7:0] op_i,
  input  logic       busy_i,
  output logic       cmd_ready_o,
  output logic       load_o,
  output logic       start_fill_o,
  output logic       start_copy_o
);
  logic is_trig, accept;

  assign is_trig      = (op_i == OP_FILL) || (op_i == OP_COPY);
  // Triggers wait for idle; loads and unknown opcodes never stall.
  assign cmd_ready_o  = !busy_i || !is_trig;
  assign accept       = cmd_valid_i && cmd_ready_o;
  assign load_o       = accept;
  assign start_fill_o = accept && (op_i == OP_FILL);
  assign start_copy_o = accept && (op_i == OP_COPY);
endmodule

// File: rtl/rect_param_regs.sv
module rect_param_regs
  import rect_blit_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DIM_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [7:0]        op_i,
  input  logic [OPER_W-1:0] operand_i,
  output logic [ADDR_W-2:0] dst_word_o,
  output logic [ADDR_W-2:0] src_word_o,
  output logic [DIM_W-1:0]  wid_o,
  output logic [DIM_W-1:0]  hgt_o
);
  logic unused_bits;
  assign unused_bits = operand_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_word_o <= '0;
      src_word_o <= '0;
      wid_o      <= '0;
      hgt_o      <= '0;
    end else if (load_i) begin
      case (op_i)
        OP_DST:  dst_word_o <= operand_i[ADDR_W-1:1];
        OP_SRC:  src_word_o <= operand_i[ADDR_W-1:1];
        OP_WID:  wid_o      <= operand_i[DIM_W-1:0];
        OP_HGT:  hgt_o      <= operand_i[DIM_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rect_walker.sv
module rect_walker
  import rect_blit_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DIM_W  = 10,
  parameter int XRES   = 64,
  parameter int PIX_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_fill_i,
  input  logic              start_copy_i,
  input  logic [PIX_W-1:0]  colour_i,
  input  logic [ADDR_W-2:0] dst_i,
  input  logic [ADDR_W-2:0] src_i,
  input  logic [DIM_W-1:0]  wid_i,
  input  logic [DIM_W-1:0]  hgt_i,
  input  logic [PIX_W-1:0]  rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-2:0] mem_addr_o,
  output logic [PIX_W-1:0]  mem_wdata_o
);
  localparam int WA_W = ADDR_W - 1;
  localparam logic [WA_W-1:0] ROW_STEP = WA_W'(XRES);

  blit_state_e state_q, state_d;
  logic [DIM_W-1:0] col_q, row_q, wlast_q, hlast_q;
  logic [WA_W-1:0]  dst_row_q, src_row_q;
  logic [PIX_W-1:0] colour_q;
  logic             done_q;
  logic             row_end, last, step;

  assign row_end = (col_q == wlast_q);
  assign last    = row_end && (row_q == hlast_q);
  assign step    = (state_q == ST_FILL) || (state_q == ST_CP_WR);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (start_fill_i)      state_d = ST_FILL;
        else if (start_copy_i) state_d = ST_CP_RD;
      end
      ST_FILL:  if (last) state_d = ST_IDLE;
      ST_CP_RD: state_d = ST_CP_WR;
      ST_CP_WR: state_d = last ? ST_IDLE : ST_CP_RD;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      col_q     <= '0;
      row_q     <= '0;
      wlast_q   <= '0;
      hlast_q   <= '0;
      dst_row_q <= '0;
      src_row_q <= '0;
      colour_q  <= '0;
      done_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      if ((start_fill_i || start_copy_i) && state_q == ST_IDLE) begin
        col_q     <= '0;
        row_q     <= '0;
        wlast_q   <= wid_i;
        hlast_q   <= hgt_i;
        dst_row_q <= dst_i;
        src_row_q <= src_i;
        if (start_fill_i) colour_q <= colour_i;
      end else if (step) begin
        if (last) done_q <= 1'b1;
        if (row_end) begin
          col_q     <= '0;
          row_q     <= row_q + 1'b1;
          dst_row_q <= dst_row_q + ROW_STEP;
          src_row_q <= src_row_q + ROW_STEP;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign mem_en_o    = busy_o;
  assign mem_we_o    = step;
  assign mem_addr_o  = ((state_q == ST_CP_RD) ? src_row_q : dst_row_q) + WA_W'(col_q);
  assign mem_wdata_o = (state_q == ST_FILL) ? colour_q : rdata_i;
endmodule

// File: rtl/rect_blit.sv
module rect_blit
  import rect_blit_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DIM_W  = 10,
  parameter int XRES   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [31:0]       cmd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-2:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i
);
  localparam int PIX_W = 16;

  logic              load, start_fill, start_copy;
  logic [ADDR_W-2:0] dst_word, src_word;
  logic [DIM_W-1:0]  wid, hgt;

  rect_cmd_decode u_dec (
    .cmd_valid_i  (cmd_valid_i),
    .op_i         (cmd_data_i[31:24]),
    .busy_i       (busy_o),
    .cmd_ready_o  (cmd_ready_o),
    .load_o       (load),
    .start_fill_o (start_fill),
    .start_copy_o (start_copy)
  );

  rect_param_regs #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .op_i       (cmd_data_i[31:24]),
    .operand_i  (cmd_data_i[OPER_W-1:0]),
    .dst_word_o (dst_word),
    .src_word_o (src_word),
    .wid_o      (wid),
    .hgt_o      (hgt)
  );

  rect_walker #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .XRES(XRES), .PIX_W(PIX_W)) u_walk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_fill_i (start_fill),
    .start_copy_i (start_copy),
    .colour_i     (cmd_data_i[PIX_W-1:0]),
    .dst_i        (dst_word),
    .src_i        (src_word),
    .wid_i        (wid),
    .hgt_i        (hgt),
    .rdata_i      (mem_rdata_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .mem_en_o     (mem_en_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o)
  );
endmodule

// File: rtl/rect_blit_chk.sv
module rect_blit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic        cmd_ready_o,
  input logic [31:0] cmd_data_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        mem_en_o,
  input logic        mem_we_o
);
  logic trig_op, param_op;
  assign trig_op  = (cmd_data_i[31:24] == 8'h0B) || (cmd_data_i[31:24] == 8'h21);
  assign param_op = (cmd_data_i[31:24] >= 8'h0C) && (cmd_data_i[31:24] <= 8'h0F);

  assert_idle_ready_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cmd_ready_o);

  assert_trig_stall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cmd_valid_i && trig_op |-> !cmd_ready_o);

  assert_load_while_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cmd_valid_i && param_op |-> cmd_ready_o);

  assert_mem_only_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> busy_o);

  assert_write_enabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_en_o);

  assert_read_then_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o && !mem_we_o |=> mem_en_o && mem_we_o);

  assert_start_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && cmd_valid_i && cmd_ready_o && trig_op |=> busy_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
endmodule

bind rect_blit rect_blit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .cmd_data_i  (cmd_data_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_en_o    (mem_en_o),
  .mem_we_o    (mem_we_o)
);

// File: tb/rect_blit_test.sv
module rect_blit_test;
  localparam int XRES  = 64;
  localparam int WORDS = 2048;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [31:0] cmd_data_i = '0;
  logic        cmd_ready_o, busy_o, done_o, mem_en_o, mem_we_o;
  logic [22:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic [15:0] mem_rdata_i = '0;

  logic [15:0] fb     [0:WORDS-1];
  logic [15:0] ref_fb [0:WORDS-1];
  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  rect_blit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .cmd_data_i(cmd_data_i), .busy_o(busy_o), .done_o(done_o), .mem_en_o(mem_en_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i)
  );

  always @(posedge clk_i) begin
    if (mem_en_o) begin
      if (mem_we_o) fb[mem_addr_o[10:0]] <= mem_wdata_o;
      else          mem_rdata_i <= fb[mem_addr_o[10:0]];
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int pix_byte(input int x, input int y);
    return (y * XRES + x) * 2;
  endfunction

  function automatic void model_fill(input int dst, input int w, input int h, input logic [15:0] c);
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++)
        ref_fb[((dst >> 1) + y * XRES + x) % WORDS] = c;
  endfunction

  function automatic void model_copy(input int src, input int dst, input int w, input int h);
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++)
        ref_fb[((dst >> 1) + y * XRES + x) % WORDS] = ref_fb[((src >> 1) + y * XRES + x) % WORDS];
  endfunction

  task automatic compare_fb(input string req);
    int bad = 0;
    int first = 0;
    for (int i = 0; i < WORDS; i++)
      if (fb[i] !== ref_fb[i]) begin
        if (bad == 0) first = i;
        bad++;
      end
    check(bad == 0, req, "frame buffer word", fb[first], ref_fb[first]);
  endtask

  task automatic send(input logic [31:0] c, output bit busy_at);
    @(negedge clk_i);
    cmd_valid_i = 1'b1;
    cmd_data_i  = c;
    while (!cmd_ready_o) @(negedge clk_i);
    busy_at = busy_o;
    @(posedge clk_i);
    #1;
    cmd_valid_i = 1'b0;
  endtask

  task automatic put(input logic [31:0] c);
    bit b;
    send(c, b);
  endtask

  // Counts busy cycles from the cycle after acceptance; checks done pulse.
  task automatic wait_done(input int exp_cycles, input bit chk_len, input string req);
    int n = 0;
    @(negedge clk_i);
    while (busy_o) begin
      n++;
      @(negedge clk_i);
    end
    if (chk_len) check(n == exp_cycles, req, "busy cycles", n, exp_cycles);
    check(done_o == 1'b1, "R7", "done at busy fall", done_o, 1);
    @(negedge clk_i);
    check(done_o == 1'b0, "R7", "done one cycle", done_o, 0);
  endtask

  task automatic do_fill(input int dst, input int w, input int h, input logic [15:0] c, input string req);
    put({8'h0C, 24'(dst)});
    put({8'h0E, 24'(w - 1)});
    put({8'h0F, 24'(h - 1)});
    put({8'h0B, 8'h00, c});
    model_fill(dst, w, h, c);
    wait_done(w * h, 1'b1, "R7");
    compare_fb(req);
  endtask

  task automatic do_copy(input int src, input int dst, input int w, input int h, input string req);
    put({8'h0D, 24'(src)});
    put({8'h0C, 24'(dst)});
    put({8'h0E, 24'(w - 1)});
    put({8'h0F, 24'(h - 1)});
    put(32'h2100_0000);
    model_copy(src, dst, w, h);
    wait_done(2 * w * h, 1'b1, "R7");
    compare_fb(req);
  endtask

  initial begin
    bit b;
    void'($urandom(32'd2718));
    for (int i = 0; i < WORDS; i++) begin
      fb[i] = 16'($urandom());
      ref_fb[i] = fb[i];
    end
    repeat (3) @(negedge clk_i);
    check(busy_o == 0, "R10", "busy in reset", busy_o, 0);
    check(done_o == 0, "R10", "done in reset", done_o, 0);
    check(mem_en_o == 0, "R10", "mem_en in reset", mem_en_o, 0);
    check(cmd_ready_o == 1, "R10", "ready in reset", cmd_ready_o, 1);
    rst_ni = 1'b1;

    // R10: zero parameters give a single pixel at word 0
    put(32'h0B00_ABCD);
    model_fill(0, 1, 1, 16'hABCD);
    wait_done(1, 1'b1, "R10");
    compare_fb("R10");

    // R2, R3, R4: odd destination byte, junk above the extent field
    put({8'h0C, 24'(pix_byte(5, 3) + 1)});
    put(32'h0E00_FC06);
    put(32'h0F00_0002);
    put(32'h0B00_F800);
    model_fill(pix_byte(5, 3), 7, 3, 16'hF800);
    wait_done(21, 1'b1, "R3");
    compare_fb("R4");

    // R5: copy, then overlapping copy in raster order
    do_copy(pix_byte(0, 0), pix_byte(20, 10), 8, 4, "R5");
    do_copy(pix_byte(20, 10), pix_byte(22, 11), 8, 4, "R5");
    do_fill(pix_byte(40, 2), 16, 2, 16'h07E0, "R6");

    // R9: unknown opcodes change nothing
    put(32'h0A00_0003);
    check(busy_o == 0, "R9", "busy after opcode 0x0A", busy_o, 0);
    put(32'h1300_0010);
    put(32'h0000_0001);
    put(32'h2200_0000);
    check(busy_o == 0, "R9", "busy after opcode 0x22", busy_o, 0);
    compare_fb("R9");
    put(32'h0B00_1234);
    model_fill(pix_byte(40, 2), 16, 2, 16'h1234);
    wait_done(32, 1'b1, "R9");
    compare_fb("R9");

    // R8, R1: loads during a running fill, trigger stall
    put({8'h0C, 24'(pix_byte(0, 20))});
    put(32'h0E00_000F);
    put(32'h0F00_0003);
    put(32'h0B00_001F);
    @(negedge clk_i);
    cmd_valid_i = 1'b1;
    cmd_data_i  = 32'h0B00_FFFF;
    #1;
    check(cmd_ready_o == 0, "R1", "trigger ready while busy", cmd_ready_o, 0);
    cmd_data_i  = 32'h2100_0000;
    #1;
    check(cmd_ready_o == 0, "R1", "copy ready while busy", cmd_ready_o, 0);
    cmd_valid_i = 1'b0;
    send({8'h0C, 24'(pix_byte(40, 25))}, b);
    check(b == 1, "R8", "dst load accepted while busy", b, 1);
    send(32'h0E00_0003, b);
    check(b == 1, "R8", "width load accepted while busy", b, 1);
    put(32'h0F00_0001);
    put({8'h0D, 24'(pix_byte(2, 2))});
    model_fill(pix_byte(0, 20), 16, 4, 16'h001F);
    wait_done(0, 1'b0, "R8");
    compare_fb("R8");
    put(32'h2100_0000);
    model_copy(pix_byte(2, 2), pix_byte(40, 25), 4, 2);
    wait_done(16, 1'b1, "R8");
    compare_fb("R8");

    // Random mix
    for (int k = 0; k < 10; k++) begin
      int dx = int'($urandom_range(0, 47));
      int dy = int'($urandom_range(0, 27));
      int w  = int'($urandom_range(1, 16));
      int h  = int'($urandom_range(1, 4));
      if (k % 2 == 0)
        do_fill(pix_byte(dx, dy), w, h, 16'($urandom()), "R4");
      else
        do_copy(pix_byte(int'($urandom_range(0, 47)), int'($urandom_range(0, 27))),
                pix_byte(dx, dy), w, h, "R5");
    end

    summary();
    $finish;
  end
endmodule